// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the access address for a synchronous burst memory. A load cycle captures a full external address and the access type (read or write). Each later advance cycle moves the burst forward by one position. Only the two lowest address bits take part in the burst; the upper bits keep the value captured at load. After four positions the sequence wraps back to its start.

The burst order comes from a static order-select input. It gives either a wrapping linear count or an XOR-style interleaved count. Internally the block keeps the loaded address and a 2-bit position count that starts at zero. The low output bits are formed from the start value and that count. An active-low clock enable freezes all state.

The memory core sits outside this block and uses `acc_addr` and `acc_write` every cycle. The access type captured at load stays in force for the whole burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after its release, before any enabled cycle, `acc_addr` is 0 and `acc_write` is 0.
- R2: A load cycle (`cke_n`=0, `adv_ld`=0) makes `acc_addr` equal the `ext_addr` sampled at that edge, from the next cycle on. The position count returns to zero.
- R3: A load cycle captures the access type: `acc_write` becomes 1 if `wr_n` was 0 at that edge, and 0 if `wr_n` was 1.
- R4: An advance cycle (`cke_n`=0, `adv_ld`=1) leaves `acc_addr[AW-1:2]` and `acc_write` unchanged, whatever `wr_n` shows.
- R5: With `order_ilv`=0 (linear), after k advances from start value s, `acc_addr[1:0]` = (s + k) mod 4.
- R6: With `order_ilv`=1 (interleaved), after k advances from start value s, `acc_addr[1:0]` = s XOR (k mod 4).
- R7: After four advances, `acc_addr` again equals the loaded address, in either order.
- R8: A cycle with `cke_n`=1 changes neither `acc_addr` nor `acc_write`, whatever `adv_ld`, `ext_addr` and `wr_n` show.
- R9: `ext_addr` has no effect during an advance cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the sequencer |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| ext_addr | input | AW | External address, sampled on load |
| wr_n | input | 1 | Active-low write request, sampled on load only |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| acc_addr | output | AW | Current access address |
| acc_write | output | 1 | Access type of the current burst, 1 = write |

## Verification
A wrong position count, or a wrong order map, shows on `acc_addr[1:0]` one cycle after the advance that produced it. A wrong count also shows on the fourth advance, when the address fails to return to the loaded value. A corrupted base register or access-type latch shows on the upper address bits or on `acc_write` in the cycle right after a load, an advance or a stalled cycle. Sweeping every start value in both orders, with stalls and conflicting inputs placed in mid-burst, exposes each of these faults within one burst of four advances.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned POS_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low address bits for a given start value and position count.
  function automatic logic [POS_W-1:0] burst_low(
    input logic [POS_W-1:0] start,
    input logic [POS_W-1:0] pos,
    input burst_order_e     order
  );
    logic [POS_W-1:0] res;
    if (order == ORD_INTERLEAVE) res = start ^ pos;
    else                         res = start + pos;
    return res;
  endfunction

endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] d_addr,
  input  logic          d_write,
  output logic [AW-1:0] base,
  output logic          write_lat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base      <= '0;
      write_lat <= 1'b0;
    end else if (ld) begin
      base      <= d_addr;
      write_lat <= d_write;
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  logic [POS_W-1:0] start,
  input  logic [POS_W-1:0] pos,
  input  logic             ilv,
  output logic [POS_W-1:0] low
);

  burst_order_e order;

  always_comb begin
    order = ilv ? ORD_INTERLEAVE : ORD_LINEAR;
    low   = burst_low(start, pos, order);
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic          adv_ld,
  input  logic [AW-1:0] ext_addr,
  input  logic          wr_n,
  input  logic          order_ilv,
  output logic [AW-1:0] acc_addr,
  output logic          acc_write
);

  localparam int unsigned UP_W = AW - POS_W;

  // Named events, visible to the bound checker.
  logic             load_fire;
  logic             adv_fire;
  logic [POS_W-1:0] pos_cnt;
  logic [AW-1:0]    base_addr;
  logic [POS_W-1:0] low_bits;

  assign load_fire = !cke_n && !adv_ld;
  assign adv_fire  = !cke_n &&  adv_ld;

  burst_step_ctr #(.CW(POS_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_fire),
    .inc   (adv_fire),
    .cnt   (pos_cnt)
  );

  burst_base_reg #(.AW(AW)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (load_fire),
    .d_addr    (ext_addr),
    .d_write   (!wr_n),
    .base      (base_addr),
    .write_lat (acc_write)
  );

  burst_order_map u_map (
    .start (base_addr[POS_W-1:0]),
    .pos   (pos_cnt),
    .ilv   (order_ilv),
    .low   (low_bits)
  );

  assign acc_addr = {base_addr[AW-1:AW-UP_W], low_bits};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          adv_ld,
  input logic [AW-1:0] ext_addr,
  input logic          wr_n,
  input logic          order_ilv,
  input logic [AW-1:0] acc_addr,
  input logic          acc_write,
  input logic [1:0]    pos_cnt
);

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(acc_addr) && $stable(acc_write))); // R8

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld) |=> (acc_addr == $past(ext_addr))); // R2

  AST_LOAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld) |=> (acc_write == !$past(wr_n))); // R3

  AST_ADV_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld) |=> ($stable(acc_addr[AW-1:2]) && $stable(acc_write))); // R4

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld && !order_ilv) |=>
      (acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1))); // R5

  AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld && order_ilv) |=>
      ((acc_addr[1:0] ^ $past(acc_addr[1:0])) == (pos_cnt ^ $past(pos_cnt)))); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (acc_addr == '0 && !acc_write)); // R1

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke_n     (cke_n),
  .adv_ld    (adv_ld),
  .ext_addr  (ext_addr),
  .wr_n      (wr_n),
  .order_ilv (order_ilv),
  .acc_addr  (acc_addr),
  .acc_write (acc_write),
  .pos_cnt   (pos_cnt)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b1;
  logic          adv_ld = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          wr_n = 1'b1;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] acc_addr;
  logic          acc_write;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) i_burst_addr_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .adv_ld    (adv_ld),
    .ext_addr  (ext_addr),
    .wr_n      (wr_n),
    .order_ilv (order_ilv),
    .acc_addr  (acc_addr),
    .acc_write (acc_write)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic a, input logic [AW-1:0] ad, input logic w);
    @(negedge clk);
    cke_n = c; adv_ld = a; ext_addr = ad; wr_n = w;
    @(posedge clk);
    #1;
  endtask

  // Expected low bits, computed per bit / by modulo.
  function automatic logic [1:0] exp_low(input int s, input int k, input int m);
    int r;
    if (m == 1) r = ((((s >> 1) & 1) != ((k >> 1) & 1)) ? 2 : 0) + (((s & 1) != (k & 1)) ? 1 : 0);
    else        r = (s + k) % 4;
    return 2'(r);
  endfunction

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(acc_addr == '0, "R1 addr", 32'(acc_addr), 0);
    check(acc_write == 1'b0, "R1 write", 32'(acc_write), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, 18'h3ffff, 1'b0);
    check(acc_addr == '0, "R1 after release", 32'(acc_addr), 0);

    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      order_ilv = 1'(m);
      for (int s = 0; s < 4; s++) begin
        logic [AW-3:0] up;
        logic [AW-1:0] ld_addr;
        logic          wrv;
        logic [AW-1:0] exp_a;
        up      = 16'(16'h1234 + s * 37 + m * 1000);
        ld_addr = {up, 2'(s)};
        wrv     = 1'(s & 1) ^ 1'(m);
        cyc(1'b0, 1'b0, ld_addr, !wrv);
        check(acc_addr == ld_addr, "R2 load addr", 32'(acc_addr), 32'(ld_addr));
        check(acc_write == wrv, "R3 load type", 32'(acc_write), 32'(wrv));
        exp_a = ld_addr;
        for (int k = 1; k <= 4; k++) begin
          if (k == 3) begin
            cyc(1'b1, 1'b0, ~ld_addr, wrv);
            check(acc_addr == exp_a, "R8 stall addr", 32'(acc_addr), 32'(exp_a));
            check(acc_write == wrv, "R8 stall type", 32'(acc_write), 32'(wrv));
            cyc(1'b1, 1'b1, ~ld_addr, wrv);
            check(acc_addr == exp_a, "R8 stall adv", 32'(acc_addr), 32'(exp_a));
          end
          cyc(1'b0, 1'b1, ~ld_addr, wrv);
          exp_a = {up, exp_low(s, k % 4, m)};
          if (m == 1)
            check(acc_addr == exp_a, "R6 R9 interleaved step", 32'(acc_addr), 32'(exp_a));
          else
            check(acc_addr == exp_a, "R5 R9 linear step", 32'(acc_addr), 32'(exp_a));
          check(acc_write == wrv, "R4 type kept", 32'(acc_write), 32'(wrv));
        end
        check(acc_addr == ld_addr, "R7 wrap", 32'(acc_addr), 32'(ld_addr));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule